// File: doc/BRIEF.md
# Reorder Buffer Retire Controller

This block keeps dispatched instructions in program order and lets them leave in that order once each has finished executing. An instruction reserves as many buffer entries as it has micro-ops. Its record sits in a slot ring that is twice as deep as the entry budget. The slot index where a record lands is handed back as a token. An execution unit later presents that token on the completion port to mark the instruction done.

Each cycle the controller starts at the oldest slot and walks forward from slot to slot. A record with `n` micro-ops is `max(1, n)` slots long, so the walk moves by that amount each step. The walk takes every consecutive completed instruction up to a per-cycle limit and presents their tags on parallel retire lanes, oldest on lane 0. The entries of retired instructions return to the free pool at the clock edge that ends that cycle. An instruction with zero micro-ops still takes one slot in the ring but uses none of the entry budget. Dispatch is therefore also gated on the number of empty slots.

Top module: `rob_retire_ctrl`

## Requirements
- R1: After reset `free_count` equals ENTRIES, `disp_token` is 0, `disp_ready` is 1, all `ret_valid` lanes are 0 and every slot is empty.
- R2: An accepted dispatch stores its record at the slot shown on `disp_token` in that cycle. The next token is the previous one plus max(1, clamped count), modulo 2*ENTRIES.
- R3: `disp_ready` is 1 only when both of these hold: `free_count` is at least the clamped count, and at least max(1, clamped count) ring slots are empty. An accepted dispatch lowers `free_count` by the clamped count at the next edge. A `disp_valid` while `disp_ready` is 0 changes nothing.
- R4: A `disp_uops` value above ENTRIES is reserved, and later returned, as exactly ENTRIES entries.
- R5: A dispatch with `disp_uops` = 0 takes one ring slot and leaves `free_count` unchanged.
- R6: A completion whose token names an occupied, not yet executed slot marks it executed. A completion aimed at an empty or already executed slot raises `cmpl_err` in the same cycle and has no effect.
- R7: Retirement is in program order. Lane i is valid only if lanes 0..i-1 are valid. Lane 0 carries the oldest instruction's tag. Only a run of executed instructions starting at the oldest retires, at the end of the cycle in which the lanes show it.
- R8: At most RETIRE_MAX instructions retire per cycle. RETIRE_MAX = 0 means no limit other than the first empty or unexecuted slot.
- R9: Retiring an instruction returns its stored entry count to `free_count` at the clock edge ending the cycle in which it is shown, and frees its slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| disp_valid | input | 1 | Dispatch request |
| disp_uops | input | UOP_W | Micro-op count of the dispatched instruction |
| disp_tag | input | TAG_W | Tag carried to the retire lanes |
| disp_ready | output | 1 | Dispatch is accepted this cycle if requested |
| disp_token | output | IDX_W | Slot index the dispatched instruction receives |
| cmpl_valid | input | 1 | Completion request |
| cmpl_token | input | IDX_W | Token of the completed instruction |
| cmpl_err | output | 1 | Completion names an empty or already executed slot |
| ret_valid | output | LANES | Per-lane retire strobe, lane 0 oldest |
| ret_tag | output | LANES*TAG_W | Tags of retiring instructions, lane i at bits i*TAG_W |
| free_count | output | CNT_W | Unreserved buffer entries |

## Verification
The bench drives two instances, one capped at two retirements per cycle and one unlimited, and compares them with a reference model. It uses random traffic plus two directed phases. The zero-micro-op phase fills the ring without touching capacity. A design that gated dispatch only on capacity would let the tail overrun the head and overwrite live records. The drain phase completes everything, so the unlimited instance must retire a long burst in one cycle. A walk that stepped by one slot instead of the stored count would hand out wrong tags there. Random tokens hit empty and already executed slots. A design that accepted such completions would then retire instructions early or out of order. Oversized counts would corrupt `free_count` if they were not clamped.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Number of ring slots a record with the given entry count occupies.
  function automatic int span_of(input int cnt);
    return (cnt == 0) ? 1 : cnt;
  endfunction

  // Ring addition for operands already below ring.
  function automatic int ring_add(input int a, input int b, input int ring);
    int s;
    s = a + b;
    return (s >= ring) ? s - ring : s;
  endfunction

endpackage

// File: rtl/rob_slot_array.sv
module rob_slot_array #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 8,
  localparam int RING   = 2 * ENTRIES,
  localparam int IDX_W  = $clog2(RING),
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [CNT_W-1:0]                wr_cnt,
  input  logic [TAG_W-1:0]                wr_tag,
  input  logic                            set_en,
  input  logic [IDX_W-1:0]                set_idx,
  input  logic [RING-1:0]                 clr_mask,
  output logic [RING-1:0]                 valid_o,
  output logic [RING-1:0]                 exec_o,
  output logic [RING-1:0][CNT_W-1:0]      cnt_o,
  output logic [RING-1:0][TAG_W-1:0]      tag_o
);

  for (genvar s = 0; s < RING; s++) begin : g_slot
    logic             v_q, v_d, e_q, e_d, en;
    logic [CNT_W-1:0] c_q, c_d;
    logic [TAG_W-1:0] t_q, t_d;

    always_comb begin
      v_d = v_q;
      e_d = e_q;
      c_d = c_q;
      t_d = t_q;
      if (clr_mask[s]) begin
        v_d = 1'b0;
        e_d = 1'b0;
        c_d = '0;
      end
      if (set_en && (set_idx == IDX_W'(s))) e_d = 1'b1;
      if (wr_en && (wr_idx == IDX_W'(s))) begin
        v_d = 1'b1;
        e_d = 1'b0;
        c_d = wr_cnt;
        t_d = wr_tag;
      end
      en = clr_mask[s] || (set_en && (set_idx == IDX_W'(s))) ||
           (wr_en && (wr_idx == IDX_W'(s)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        e_q <= 1'b0;
        c_q <= '0;
        t_q <= '0;
      end else if (en) begin
        v_q <= v_d;
        e_q <= e_d;
        c_q <= c_d;
        t_q <= t_d;
      end
    end

    assign valid_o[s] = v_q;
    assign exec_o[s]  = e_q;
    assign cnt_o[s]   = c_q;
    assign tag_o[s]   = t_q;
  end

endmodule

// File: rtl/rob_retire_walk.sv
module rob_retire_walk
  import rob_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 8,
  parameter int LANES   = 2,
  localparam int RING    = 2 * ENTRIES,
  localparam int IDX_W   = $clog2(RING),
  localparam int CNT_W   = $clog2(ENTRIES + 1),
  localparam int SLOTS_W = $clog2(RING + 1)
) (
  input  logic [IDX_W-1:0]              head,
  input  logic [RING-1:0]               valid,
  input  logic [RING-1:0]               exec,
  input  logic [RING-1:0][CNT_W-1:0]    cnt,
  input  logic [RING-1:0][TAG_W-1:0]    tag,
  output logic [LANES-1:0]              ret_valid,
  output logic [LANES-1:0][TAG_W-1:0]   ret_tag,
  output logic [RING-1:0]               clr_mask,
  output logic [CNT_W-1:0]              ret_cnt,
  output logic [SLOTS_W-1:0]            ret_slots,
  output logic [IDX_W-1:0]              new_head
);

  always_comb begin
    int p, c, st, rc, rs;
    logic go, ok;
    p         = int'(head);
    go        = 1'b1;
    rc        = 0;
    rs        = 0;
    clr_mask  = '0;
    new_head  = head;
    ret_valid = '0;
    ret_tag   = '0;
    for (int i = 0; i < LANES; i++) begin
      c  = int'(cnt[p]);
      st = span_of(c);
      ok = go && valid[p] && exec[p];
      ret_valid[i] = ok;
      ret_tag[i]   = tag[p];
      if (ok) begin
        clr_mask[p] = 1'b1;
        rc          = rc + c;
        rs          = rs + st;
        new_head    = IDX_W'(ring_add(p, st, RING));
      end
      go = ok;
      p  = ring_add(p, st, RING);
    end
    ret_cnt   = CNT_W'(rc);
    ret_slots = SLOTS_W'(rs);
  end

endmodule

// File: rtl/rob_alloc.sv
module rob_alloc
  import rob_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int RING    = 2 * ENTRIES,
  localparam int IDX_W   = $clog2(RING),
  localparam int CNT_W   = $clog2(ENTRIES + 1),
  localparam int SLOTS_W = $clog2(RING + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               disp_valid,
  input  logic [CNT_W-1:0]   disp_cnt,
  input  logic [CNT_W-1:0]   ret_cnt,
  input  logic [SLOTS_W-1:0] ret_slots,
  input  logic [IDX_W-1:0]   new_head,
  output logic               disp_ready,
  output logic               disp_fire,
  output logic [IDX_W-1:0]   head,
  output logic [IDX_W-1:0]   tail,
  output logic [CNT_W-1:0]   free_cnt
);

  logic [IDX_W-1:0]   head_d, tail_d;
  logic [CNT_W-1:0]   free_d;
  logic [SLOTS_W-1:0] used_q, used_d;
  logic               en;

  always_comb begin
    int need, cap, slots;
    need       = span_of(int'(disp_cnt));
    disp_ready = (int'(free_cnt) >= int'(disp_cnt)) &&
                 ((RING - int'(used_q)) >= need);
    disp_fire  = disp_valid && disp_ready;
    cap        = int'(free_cnt) + int'(ret_cnt) - (disp_fire ? int'(disp_cnt) : 0);
    slots      = int'(used_q) - int'(ret_slots) + (disp_fire ? need : 0);
    free_d     = CNT_W'(cap);
    used_d     = SLOTS_W'(slots);
    head_d     = new_head;
    tail_d     = disp_fire ? IDX_W'(ring_add(int'(tail), need, RING)) : tail;
    en         = disp_fire || (ret_slots != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head     <= '0;
      tail     <= '0;
      free_cnt <= CNT_W'(ENTRIES);
      used_q   <= '0;
    end else if (en) begin
      head     <= head_d;
      tail     <= tail_d;
      free_cnt <= free_d;
      used_q   <= used_d;
    end
  end

  // R3: capacity never exceeds the configured budget
  a_r3_cap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CNT_W'(ENTRIES));

  // R9: an empty ring holds the whole budget
  a_r9_empty_full: assert property (@(posedge clk) disable iff (!rst_n)
    (used_q == '0) |-> (free_cnt == CNT_W'(ENTRIES)));

  // R5: zero-count dispatch with no retirement leaves capacity alone
  a_r5_zero_no_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_fire && disp_cnt == '0 && ret_cnt == '0) |=> $stable(free_cnt));

endmodule

// File: rtl/rob_retire_ctrl.sv
module rob_retire_ctrl #(
  parameter int ENTRIES    = 8,
  parameter int UOP_W      = 4,
  parameter int TAG_W      = 8,
  parameter int RETIRE_MAX = 2,
  localparam int RING    = 2 * ENTRIES,
  localparam int IDX_W   = $clog2(RING),
  localparam int CNT_W   = $clog2(ENTRIES + 1),
  localparam int SLOTS_W = $clog2(RING + 1),
  localparam int LANES   = (RETIRE_MAX == 0 || RETIRE_MAX > RING) ? RING : RETIRE_MAX
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   disp_valid,
  input  logic [UOP_W-1:0]       disp_uops,
  input  logic [TAG_W-1:0]       disp_tag,
  output logic                   disp_ready,
  output logic [IDX_W-1:0]       disp_token,
  input  logic                   cmpl_valid,
  input  logic [IDX_W-1:0]       cmpl_token,
  output logic                   cmpl_err,
  output logic [LANES-1:0]       ret_valid,
  output logic [LANES*TAG_W-1:0] ret_tag,
  output logic [CNT_W-1:0]       free_count
);

  logic [CNT_W-1:0]           disp_cnt, ret_cnt;
  logic [SLOTS_W-1:0]         ret_slots;
  logic [IDX_W-1:0]           head, tail, new_head;
  logic                       disp_fire, cmpl_ok;
  logic [RING-1:0]            valid, exec, clr_mask;
  logic [RING-1:0][CNT_W-1:0] cnt;
  logic [RING-1:0][TAG_W-1:0] tag;
  logic [LANES-1:0][TAG_W-1:0] lane_tag;

  // Clamp the reservation to the buffer size (R4)
  always_comb begin
    if (int'(disp_uops) > ENTRIES) disp_cnt = CNT_W'(ENTRIES);
    else                           disp_cnt = CNT_W'(disp_uops);
  end

  // Completion is legal only for an occupied slot not yet executed (R6)
  always_comb begin
    cmpl_ok  = cmpl_valid && (int'(cmpl_token) < RING) &&
               valid[cmpl_token] && !exec[cmpl_token];
    cmpl_err = cmpl_valid && !cmpl_ok;
  end

  rob_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_valid (disp_valid),
    .disp_cnt   (disp_cnt),
    .ret_cnt    (ret_cnt),
    .ret_slots  (ret_slots),
    .new_head   (new_head),
    .disp_ready (disp_ready),
    .disp_fire  (disp_fire),
    .head       (head),
    .tail       (tail),
    .free_cnt   (free_count)
  );

  rob_slot_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (disp_fire),
    .wr_idx   (tail),
    .wr_cnt   (disp_cnt),
    .wr_tag   (disp_tag),
    .set_en   (cmpl_ok),
    .set_idx  (cmpl_token),
    .clr_mask (clr_mask),
    .valid_o  (valid),
    .exec_o   (exec),
    .cnt_o    (cnt),
    .tag_o    (tag)
  );

  rob_retire_walk #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .LANES(LANES)) u_walk (
    .head      (head),
    .valid     (valid),
    .exec      (exec),
    .cnt       (cnt),
    .tag       (tag),
    .ret_valid (ret_valid),
    .ret_tag   (lane_tag),
    .clr_mask  (clr_mask),
    .ret_cnt   (ret_cnt),
    .ret_slots (ret_slots),
    .new_head  (new_head)
  );

  assign disp_token = tail;
  assign ret_tag    = lane_tag;

  // R2: the slot named by the token holds a fresh record after dispatch
  a_r2_token_written: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |=> (valid[$past(disp_token)] && !exec[$past(disp_token)]));

  // R7: lanes fill from lane 0 without gaps
  for (genvar i = 1; i < LANES; i++) begin : g_order
    a_r7_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid[i] |-> ret_valid[i-1]);
  end

  // R9: retiring without dispatch never lowers capacity
  a_r9_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid[0] && !disp_fire) |=> (free_count >= $past(free_count)));

  // R6: a rejected completion leaves the named slot's executed flag as it was
  a_r6_err_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_err && int'(cmpl_token) < RING && !valid[cmpl_token] && !disp_fire)
      |=> !exec[$past(cmpl_token)]);

endmodule

// File: tb/sim_rob_retire_ctrl.sv
module sim_rob_retire_ctrl;
  localparam int ENT  = 8;
  localparam int RING = 16;
  localparam int NCYC = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       dv [2];
  logic [3:0] du [2];
  logic [7:0] dt [2];
  logic       cv [2];
  logic [3:0] ct [2];

  logic         rdy0, rdy1, err0, err1;
  logic [3:0]   tok0, tok1, fc0, fc1;
  logic [1:0]   rv0;
  logic [15:0]  rt0, rv1;
  logic [127:0] rt1;

  rob_retire_ctrl #(.ENTRIES(ENT), .UOP_W(4), .TAG_W(8), .RETIRE_MAX(2)) u0 (
    .clk(clk), .rst_n(rst_n), .disp_valid(dv[0]), .disp_uops(du[0]), .disp_tag(dt[0]),
    .disp_ready(rdy0), .disp_token(tok0), .cmpl_valid(cv[0]), .cmpl_token(ct[0]),
    .cmpl_err(err0), .ret_valid(rv0), .ret_tag(rt0), .free_count(fc0));

  rob_retire_ctrl #(.ENTRIES(ENT), .UOP_W(4), .TAG_W(8), .RETIRE_MAX(0)) u1 (
    .clk(clk), .rst_n(rst_n), .disp_valid(dv[1]), .disp_uops(du[1]), .disp_tag(dt[1]),
    .disp_ready(rdy1), .disp_token(tok1), .cmpl_valid(cv[1]), .cmpl_token(ct[1]),
    .cmpl_err(err1), .ret_valid(rv1), .ret_tag(rt1), .free_count(fc1));

  // reference state
  bit mv [2][RING];
  bit me [2][RING];
  int mc [2][RING];
  int mtag [2][RING];
  int mh [2], mt [2], mf [2], mu [2];
  int er_pos [2][RING];
  int er_k [2];
  bit e_rdy [2];
  bit e_err [2];

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int span(input int c);
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int clampc(input int u);
    return (u > ENT) ? ENT : u;
  endfunction

  function automatic int lim_of(input int n);
    return (n == 0) ? 2 : RING;
  endfunction

  function automatic int o_rdy(input int n);  return (n == 0) ? int'(rdy0) : int'(rdy1); endfunction
  function automatic int o_tok(input int n);  return (n == 0) ? int'(tok0) : int'(tok1); endfunction
  function automatic int o_fc(input int n);   return (n == 0) ? int'(fc0)  : int'(fc1);  endfunction
  function automatic int o_err(input int n);  return (n == 0) ? int'(err0) : int'(err1); endfunction
  function automatic int o_rv(input int n, input int l);
    return (n == 0) ? int'(rv0[l]) : int'(rv1[l]);
  endfunction
  function automatic int o_rt(input int n, input int l);
    return (n == 0) ? int'(rt0[l*8 +: 8]) : int'(rt1[l*8 +: 8]);
  endfunction

  function automatic int pick_cmpl(input int n);
    int cnt, sel;
    cnt = 0;
    for (int i = 0; i < RING; i++) begin
      int q = (mh[n] + i) % RING;
      if (mv[n][q] && !me[n][q]) cnt++;
    end
    if (cnt == 0) return int'($urandom % RING);
    sel = int'($urandom % cnt);
    for (int i = 0; i < RING; i++) begin
      int q = (mh[n] + i) % RING;
      if (mv[n][q] && !me[n][q]) begin
        if (sel == 0) return q;
        sel--;
      end
    end
    return 0;
  endfunction

  task automatic model_reset();
    for (int n = 0; n < 2; n++) begin
      for (int s = 0; s < RING; s++) begin
        mv[n][s] = 0; me[n][s] = 0; mc[n][s] = 0; mtag[n][s] = 0;
      end
      mh[n] = 0; mt[n] = 0; mf[n] = ENT; mu[n] = 0;
    end
  endtask

  task automatic compute(input int n);
    int p, k, c, need;
    p = mh[n];
    k = 0;
    while (k < lim_of(n) && mv[n][p] && me[n][p]) begin
      er_pos[n][k] = p;
      k++;
      p = (p + span(mc[n][p])) % RING;
    end
    er_k[n] = k;
    c = clampc(int'(du[n]));
    need = span(c);
    e_rdy[n] = (mf[n] >= c) && ((RING - mu[n]) >= need);
    e_err[n] = cv[n] && !(mv[n][ct[n]] && !me[n][ct[n]]);
  endtask

  task automatic check_out(input int n);
    chk("R2 token", o_tok(n), mt[n]);
    chk("R3 ready", o_rdy(n), int'(e_rdy[n]));
    chk("R9 free_count", o_fc(n), mf[n]);
    chk("R6 cmpl_err", o_err(n), int'(e_err[n]));
    for (int l = 0; l < lim_of(n); l++) begin
      chk((n == 0) ? "R8 lane valid (limit 2)" : "R8 lane valid (unlimited)",
          o_rv(n, l), int'(l < er_k[n]));
      if (l < er_k[n]) chk("R7 lane tag", o_rt(n, l), mtag[n][er_pos[n][l]]);
    end
  endtask

  task automatic model_step(input int n);
    int p, c, need;
    for (int j = 0; j < er_k[n]; j++) begin
      p = er_pos[n][j];
      mf[n] += mc[n][p];
      mu[n] -= span(mc[n][p]);
      mh[n] = (p + span(mc[n][p])) % RING;
      mv[n][p] = 0; me[n][p] = 0; mc[n][p] = 0;
    end
    if (cv[n] && !e_err[n]) me[n][ct[n]] = 1;
    if (dv[n] && e_rdy[n]) begin
      c = clampc(int'(du[n]));
      need = span(c);
      mv[n][mt[n]] = 1; me[n][mt[n]] = 0; mc[n][mt[n]] = c; mtag[n][mt[n]] = int'(dt[n]);
      mt[n] = (mt[n] + need) % RING;
      mf[n] -= c;
      mu[n] += need;
    end
  endtask

  task automatic stim(input int n, input int cyc);
    int r;
    dt[n] = 8'($urandom);
    if (cyc >= 1500 && cyc < 1600) begin
      // R5: zero-count records fill the ring without touching capacity
      dv[n] = 1'b1; du[n] = 4'd0; cv[n] = 1'b0; ct[n] = 4'd0;
    end else if (cyc >= 1600 && cyc < 1700) begin
      dv[n] = 1'b0; du[n] = 4'd0; cv[n] = 1'b1; ct[n] = 4'(pick_cmpl(n));
    end else begin
      dv[n] = ($urandom % 10) < 7;
      r = int'($urandom % 10);
      if (r < 2)      du[n] = 4'd0;
      else if (r < 3) du[n] = 4'(9 + $urandom % 7);  // R4: oversized counts
      else            du[n] = 4'(1 + $urandom % 8);
      cv[n] = ($urandom % 10) < 8;
      ct[n] = (($urandom % 10) == 0) ? 4'($urandom % RING) : 4'(pick_cmpl(n));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int n = 0; n < 2; n++) begin
      dv[n] = 0; du[n] = 0; dt[n] = 0; cv[n] = 0; ct[n] = 0;
    end
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 free_count", int'(fc0), ENT);
    chk("R1 token", int'(tok0), 0);
    chk("R1 ready", int'(rdy0), 1);
    chk("R1 no retire", int'(rv0), 0);
    chk("R1 no retire unlimited", int'(rv1), 0);
    chk("R1 free_count unlimited", int'(fc1), ENT);
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      for (int n = 0; n < 2; n++) stim(n, cyc);
      #1;
      for (int n = 0; n < 2; n++) begin
        compute(n);
        check_out(n);
      end
      @(posedge clk);
      for (int n = 0; n < 2; n++) model_step(n);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule